// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is a two-wire serial bus slave that keeps a small bank of 8-bit configuration registers for a clock-generator control plane. A bus master reaches it at one fixed device address and moves data with four transfer kinds: single-register writes and reads selected by a command byte, and block writes and reads that always begin at register 0 and walk through the bank in order.

Every register's current contents are presented on one wide parallel output, so the rest of the chip reads its settings without touching the bus. One register is a constant identity byte that ignores writes. Another register carries externally latched status bits in its low field, taken live from a parallel input and protected from writes, while its upper bits remain writable. The bus clock and data lines are brought into the system clock domain by a two-stage synchroniser, and the data line is only ever pulled low by the block.

Top module: `smb_cfg_bank`

## Requirements
- R1: The block acknowledges address byte D2h (write) and D3h (read); any other address byte gets no acknowledge and the block stays off the data line until the next start condition.
- R2: A single-register write (D2h, command c with 1 <= c < 22, one data byte) stores the byte in register c, and the new value appears on `cfg_o[8c+7:8c]`.
- R3: A single-register read (D2h, command c, repeated start, D3h) returns the current value of register c, most significant bit first.
- R4: Command 00h selects block mode; a block write (D2h, 00h, count N, data) stores data byte k in register k for k < N, acknowledges those bytes, and leaves bytes past the count unacknowledged and unstored.
- R5: A block read (D2h, 00h, repeated start, D3h) first returns the count byte 22 (16h), then register 0, 1, 2 ... in order until the master withholds its acknowledge.
- R6: Register 7 always reads 77h; writes addressed to it are acknowledged and have no effect.
- R7: In register 2, bits [4:0] always show `strap_i`; they cannot be written, while bits [7:5] are writable.
- R8: After reset, registers 15, 16, 19 and 20 hold 2Ch, 24h, D2h and 88h; register 7 holds 77h; all other writable bits are 0.
- R9: A register index of 22 or above is never written: its data byte gets no acknowledge, and a read from it returns 00h.
- R10: The data line driver changes state only while the bus clock is low, and is released after any start or stop condition.
- R11: A single-register write accepts exactly one data byte; a second data byte in the same transfer is not acknowledged and not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | High pulls the data line low (open drain) |
| strap_i | input | 5 | Externally latched status bits shown in register 2 |
| cfg_o | output | 176 | All 22 register bytes, register k at bits [8k+7:8k] |

## Verification
Random single-register writes and reads over indices 1 to 25 separate the in-range store path from the out-of-range refusal and catch a read pointer that is off by one. Block writes of random length, each followed by one surplus byte, distinguish the byte-count limit from the bank-size limit, and full block reads with one byte past the bank tell the count byte apart from register data and confirm the zero fill. Directed cases aim data at the identity and status registers, change `strap_i` between reads, send a foreign address, and append a second byte to a single write, while a bench monitor watches that the data driver only moves while the clock is low.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_RX,
        LK_RACK,
        LK_TX,
        LK_TACK
    } lk_state_e;

    typedef enum logic [1:0] {
        RL_ADDR,
        RL_CMD,
        RL_CNT,
        RL_DATA
    } lk_role_e;

    typedef struct packed {
        lk_state_e  st;
        lk_role_e   role;
        logic [3:0] bitn;
        logic [7:0] sh;
        logic [7:0] ptr;
        logic [7:0] cnt;
        logic       rd;
        logic       blk;
        logic       cpend;
        logic       wdone;
        logic       mack;
        logic       oe;
    } lk_state_t;

    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            15:      return 8'h2C;
            16:      return 8'h24;
            19:      return 8'hD2;
            20:      return 8'h88;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_pin_sync.sv
module smb_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    // bit 0 = clock line, bit 1 = data line
    logic [1:0] m1_q, m2_q, prv_q;
    logic [1:0] m1_d, m2_d, prv_d;

    always_comb begin
        m1_d  = {sda_i, scl_i};
        m2_d  = m1_q;
        prv_d = m2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m1_q  <= 2'b11;
            m2_q  <= 2'b11;
            prv_q <= 2'b11;
        end else begin
            m1_q  <= m1_d;
            m2_q  <= m2_d;
            prv_q <= prv_d;
        end
    end

    assign scl_s    = m2_q[0];
    assign sda_s    = m2_q[1];
    assign scl_rise = m2_q[0] & ~prv_q[0];
    assign scl_fall = ~m2_q[0] & prv_q[0];
    assign start_ev = m2_q[0] & prv_q[0] & ~m2_q[1] & prv_q[1];
    assign stop_ev  = m2_q[0] & prv_q[0] & m2_q[1] & ~prv_q[1];

endmodule

// File: rtl/smb_link.sv
module smb_link
    import smb_cfg_pkg::*;
#(
    parameter int         NREG     = 22,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic [7:0] rd_dat,
    output logic [7:0] rd_idx,
    output logic       wr_en,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_dat,
    output logic       sda_oe
);
    localparam logic [7:0] NREG8 = 8'(NREG);

    lk_state_t q, d;
    logic [7:0] nxt_byte;
    logic       data_ok;

    always_comb begin
        d        = q;
        wr_en    = 1'b0;
        wr_idx   = q.ptr;
        wr_dat   = q.sh;
        nxt_byte = q.cpend ? NREG8 : rd_dat;
        data_ok  = (q.blk ? (q.cnt != 8'd0) : !q.wdone) && (q.ptr < NREG8);

        if (start_ev) begin
            d.st   = LK_RX;
            d.role = RL_ADDR;
            d.bitn = 4'd0;
            d.rd   = 1'b0;
            d.oe   = 1'b0;
        end else if (stop_ev) begin
            d.st = LK_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                LK_RX: begin
                    if (scl_rise && q.bitn < 4'd8) begin
                        d.sh   = {q.sh[6:0], sda_s};
                        d.bitn = q.bitn + 4'd1;
                    end
                    if (scl_fall && q.bitn == 4'd8) begin
                        d.bitn = 4'd0;
                        d.st   = LK_RACK;
                        d.oe   = 1'b0;
                        case (q.role)
                            RL_ADDR: begin
                                if (q.sh[7:1] == DEV_ADDR) begin
                                    d.oe = 1'b1;
                                    d.rd = q.sh[0];
                                    if (q.sh[0]) d.cpend = q.blk;
                                    else         d.role  = RL_CMD;
                                end else begin
                                    d.st = LK_IDLE;
                                end
                            end
                            RL_CMD: begin
                                d.ptr   = q.sh;
                                d.blk   = (q.sh == 8'd0);
                                d.role  = (q.sh == 8'd0) ? RL_CNT : RL_DATA;
                                d.wdone = 1'b0;
                                d.oe    = 1'b1;
                            end
                            RL_CNT: begin
                                d.cnt  = q.sh;
                                d.role = RL_DATA;
                                d.oe   = 1'b1;
                            end
                            default: begin
                                if (data_ok) begin
                                    wr_en   = 1'b1;
                                    d.oe    = 1'b1;
                                    d.ptr   = q.ptr + 8'd1;
                                    d.wdone = 1'b1;
                                    if (q.blk) d.cnt = q.cnt - 8'd1;
                                end
                            end
                        endcase
                    end
                end
                LK_RACK: begin
                    if (scl_fall) begin
                        d.oe   = 1'b0;
                        d.bitn = 4'd0;
                        d.st   = LK_RX;
                        if (q.rd) begin
                            d.st   = LK_TX;
                            d.sh   = nxt_byte;
                            d.oe   = ~nxt_byte[7];
                            d.bitn = 4'd1;
                            if (q.cpend)              d.cpend = 1'b0;
                            else if (q.ptr != 8'hFF)  d.ptr   = q.ptr + 8'd1;
                        end
                    end
                end
                LK_TX: begin
                    if (scl_fall) begin
                        if (q.bitn == 4'd8) begin
                            d.oe = 1'b0;
                            d.st = LK_TACK;
                        end else begin
                            d.oe   = ~q.sh[6];
                            d.sh   = {q.sh[6:0], 1'b0};
                            d.bitn = q.bitn + 4'd1;
                        end
                    end
                end
                LK_TACK: begin
                    if (scl_rise) d.mack = ~sda_s;
                    if (scl_fall) begin
                        if (q.mack) begin
                            d.st   = LK_TX;
                            d.sh   = nxt_byte;
                            d.oe   = ~nxt_byte[7];
                            d.bitn = 4'd1;
                            if (q.cpend)              d.cpend = 1'b0;
                            else if (q.ptr != 8'hFF)  d.ptr   = q.ptr + 8'd1;
                        end else begin
                            d.st = LK_IDLE;
                            d.oe = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: LK_IDLE, role: RL_ADDR, bitn: 4'd0, sh: 8'd0, ptr: 8'd0,
                   cnt: 8'd0, rd: 1'b0, blk: 1'b0, cpend: 1'b0, wdone: 1'b0,
                   mack: 1'b0, oe: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign rd_idx = q.ptr;
    assign sda_oe = q.oe;

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
    import smb_cfg_pkg::*;
#(
    parameter int         NREG    = 22,
    parameter int         ID_IDX  = 7,
    parameter logic [7:0] ID_VAL  = 8'h77,
    parameter int         STS_IDX = 2,
    parameter int         STS_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_idx,
    input  logic [7:0]        wr_dat,
    input  logic [7:0]        rd_idx,
    output logic [7:0]        rd_dat,
    input  logic [STS_W-1:0]  strap_i,
    output logic [NREG*8-1:0] cfg_o
);
    localparam int HI_W = 8 - STS_W;

    logic [7:0] view [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [7:0] DEF = reg_default(i);
        if (i == ID_IDX) begin : g_id
            assign view[i] = ID_VAL;
        end else if (i == STS_IDX) begin : g_sts
            logic [HI_W-1:0] hi_q, hi_d;
            always_comb begin
                hi_d = hi_q;
                if (wr_en && wr_idx == 8'(i)) hi_d = wr_dat[7:STS_W];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) hi_q <= DEF[7:STS_W];
                else        hi_q <= hi_d;
            end
            assign view[i] = {hi_q, strap_i};
        end else begin : g_rw
            logic [7:0] b_q, b_d;
            always_comb begin
                b_d = b_q;
                if (wr_en && wr_idx == 8'(i)) b_d = wr_dat;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) b_q <= DEF;
                else        b_q <= b_d;
            end
            assign view[i] = b_q;
        end
        assign cfg_o[i*8 +: 8] = view[i];
    end

    always_comb begin
        rd_dat = 8'h00;
        for (int k = 0; k < NREG; k++) begin
            if (rd_idx == 8'(k)) rd_dat = view[k];
        end
    end

endmodule

// File: rtl/smb_cfg_bank.sv
module smb_cfg_bank
    import smb_cfg_pkg::*;
#(
    parameter int         NREG     = 22,
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         ID_IDX   = 7,
    parameter logic [7:0] ID_VAL   = 8'h77,
    parameter int         STS_IDX  = 2,
    parameter int         STS_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [STS_W-1:0]  strap_i,
    output logic [NREG*8-1:0] cfg_o
);
    logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic       wr_en;
    logic [7:0] wr_idx, wr_dat, rd_idx, rd_dat;

    smb_pin_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    smb_link #(
        .NREG     (NREG),
        .DEV_ADDR (DEV_ADDR)
    ) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rd_dat   (rd_dat),
        .rd_idx   (rd_idx),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_dat   (wr_dat),
        .sda_oe   (sda_oe_o)
    );

    smb_regbank #(
        .NREG    (NREG),
        .ID_IDX  (ID_IDX),
        .ID_VAL  (ID_VAL),
        .STS_IDX (STS_IDX),
        .STS_W   (STS_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_dat  (wr_dat),
        .rd_idx  (rd_idx),
        .rd_dat  (rd_dat),
        .strap_i (strap_i),
        .cfg_o   (cfg_o)
    );

endmodule

// File: rtl/smb_cfg_bank_chk.sv
module smb_cfg_bank_chk #(
    parameter int NREG   = 22,
    parameter int ID_IDX = 7
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe_o,
    input logic       scl_s,
    input logic       start_ev,
    input logic       stop_ev,
    input logic       wr_en,
    input logic [7:0] wr_idx,
    input logic [7:0] id_byte
);
    // R10
    oe_moves_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> $past(!scl_s));

    // R10
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_oe_o);

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe_o);

    // R6
    id_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 8'(ID_IDX)) |=> $stable(id_byte));

    // R9
    wr_in_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < 8'(NREG)));

endmodule

bind smb_cfg_bank smb_cfg_bank_chk #(
    .NREG   (NREG),
    .ID_IDX (ID_IDX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe_o (sda_oe_o),
    .scl_s    (scl_s),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .id_byte  (cfg_o[ID_IDX*8 +: 8])
);

// File: tb/smb_cfg_bank_test.sv
module smb_cfg_bank_test;
    localparam int NREG = 22;
    localparam int Q    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic [4:0] strap = 5'h15;
    logic [NREG*8-1:0] cfg;

    int total = 0;
    int bad = 0;
    int viol = 0;
    bit done = 0;
    logic [7:0] mem [NREG];

    always #10 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    smb_cfg_bank uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe),
        .strap_i  (strap),
        .cfg_o    (cfg)
    );

    function automatic logic [7:0] def_of(int i);
        if (i == 15) return 8'h2C;
        if (i == 16) return 8'h24;
        if (i == 19) return 8'hD2;
        if (i == 20) return 8'h88;
        return 8'h00;
    endfunction

    function automatic logic [7:0] view(int i);
        if (i >= NREG) return 8'h00;
        if (i == 7)    return 8'h77;
        if (i == 2)    return {mem[2][7:5], strap};
        return mem[i];
    endfunction

    function automatic void apply(int i, logic [7:0] v);
        if (i < NREG && i != 7) mem[i] = v;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_cfg(input string tag);
        for (int i = 0; i < NREG; i++)
            chk(cfg[i*8 +: 8] == view(i), tag, int'(cfg[i*8 +: 8]), int'(view(i)));
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic send(input logic [7:0] b, output bit ack);
        for (int k = 7; k >= 0; k--) begin
            m_sda = b[k]; wq(Q);
            m_scl = 1'b1; wq(2*Q);
            m_scl = 1'b0; wq(Q);
        end
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        ack = ~sda_bus; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic recv(input bit ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int k = 7; k >= 0; k--) begin
            wq(Q);
            m_scl = 1'b1; wq(Q);
            b[k] = sda_bus; wq(Q);
            m_scl = 1'b0;
        end
        wq(Q);
        m_sda = ~ack; wq(Q);
        m_scl = 1'b1; wq(2*Q);
        m_scl = 1'b0; wq(Q);
        m_sda = 1'b1;
    endtask

    task automatic byte_write(input int idx, input logic [7:0] v);
        bit a0, a1, a2;
        bus_start();
        send(8'hD2, a0);
        send(8'(idx), a1);
        send(v, a2);
        bus_stop();
        chk(a0 && a1, "R1 write address/command ack", int'({a0, a1}), 3);
        chk(a2 == (idx < NREG), "R2/R9 data ack", int'(a2), int'(idx < NREG));
        apply(idx, v);
        chk_cfg("R2/R6/R7 cfg after byte write");
    endtask

    task automatic byte_read(input int idx);
        bit a0, a1, a2;
        logic [7:0] b;
        bus_start();
        send(8'hD2, a0);
        send(8'(idx), a1);
        bus_start();
        send(8'hD3, a2);
        recv(1'b0, b);
        bus_stop();
        chk(a0 && a1 && a2, "R1 read acks", int'({a0, a1, a2}), 7);
        chk(b == view(idx), "R3/R9 byte read", int'(b), int'(view(idx)));
    endtask

    task automatic block_write(input int n);
        bit a;
        logic [7:0] v;
        bus_start();
        send(8'hD2, a);
        send(8'h00, a);
        send(8'(n), a);
        chk(a, "R4 count ack", int'(a), 1);
        for (int k = 0; k <= n; k++) begin
            v = 8'($urandom);
            send(v, a);
            chk(a == (k < n), "R4 block data ack", int'(a), int'(k < n));
            if (k < n) apply(k, v);
        end
        bus_stop();
        chk_cfg("R4 cfg after block write");
    endtask

    task automatic block_read();
        bit a0, a1, a2;
        logic [7:0] b;
        bus_start();
        send(8'hD2, a0);
        send(8'h00, a1);
        bus_start();
        send(8'hD3, a2);
        recv(1'b1, b);
        chk(b == 8'(NREG), "R5 count byte", int'(b), NREG);
        for (int k = 0; k <= NREG; k++) begin
            recv(k < NREG, b);
            chk(b == view(k), "R5/R9 block read byte", int'(b), int'(view(k)));
        end
        bus_stop();
    endtask

    always @(negedge clk) begin : mon_r10
        logic prev;
        if (rst_n && m_scl && sda_oe != prev) viol++;
        prev = sda_oe;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        bit a;
        logic [7:0] b;
        void'($urandom(32'd7531));
        for (int i = 0; i < NREG; i++) mem[i] = def_of(i);
        wq(5);
        chk(sda_oe == 1'b0, "R10 reset driver off", int'(sda_oe), 0);
        rst_n = 1'b1;
        wq(5);
        chk_cfg("R8 reset defaults");

        // R1: foreign address then a further byte: both unanswered
        bus_start();
        send(8'hD4, a);
        chk(!a, "R1 foreign address nack", int'(a), 0);
        send(8'h00, a);
        chk(!a, "R1 silent until start", int'(a), 0);
        bus_stop();

        // R6 / R7 directed
        byte_write(7, 8'h00);
        byte_read(7);
        byte_write(2, 8'hFF);
        byte_read(2);
        strap = 5'h0A;
        wq(4);
        chk_cfg("R7 strap follows");
        byte_read(2);

        // R11: second data byte refused
        bus_start();
        send(8'hD2, a);
        send(8'd5, a);
        send(8'h5A, a);
        send(8'hA5, a);
        chk(!a, "R11 second data nack", int'(a), 0);
        bus_stop();
        apply(5, 8'h5A);
        chk_cfg("R11 only first byte stored");

        // R9 directed
        byte_write(NREG, 8'h33);
        byte_read(NREG + 2);

        block_read();
        block_write(NREG);
        block_read();

        for (int n = 0; n < 36; n++) begin
            int idx;
            idx = 1 + int'($urandom % (NREG + 3));
            if ($urandom % 2) byte_write(idx, 8'($urandom));
            else              byte_read(idx);
        end

        block_write(1 + int'($urandom % NREG));
        block_read();

        // R10 summary of bench-side driver monitor
        chk(viol == 0, "R10 driver change while clock high", viol, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule